// File: doc/BRIEF.md
# Buffered Input Capture Unit

This block timestamps pin transitions. Each of `N_CH` capture channels watches one pin. When the pin makes the transition chosen by that channel's 2-bit edge code, the channel copies the external free-running counter value `cnt_i` into its capture register and raises its flag. A flag drives an interrupt output when that channel's interrupt enable is set. Every pin passes through a two-flop synchroniser before any edge is detected.

The first `N_BUF` channels are buffered. Each has a holding register, a delay filter for rejecting noise, a no-overwrite option and a record of the polarity of its first capture. The holding registers work in one of two modes:

- **Queue mode:** each capture pushes the previous capture value into the holding register.
- **Latch mode:** all buffered capture registers copy into their holding registers together, either on an external strobe (for example a down-counter reaching zero) or on a software latch write.

Software reaches all state through a simple single-cycle register port.

Top module: `buf_capture_unit`

Register map (word addresses):

| Address | Contents |
|---|---|
| 0x00 | Edge codes; channel c uses bits [2c+1:2c] |
| 0x01 | Control word (bits listed below) |
| 0x02 | Flags; write 1 to clear |
| 0x03 | Interrupt enables |
| 0x04 | Polarity record; write 1 to re-arm |
| 0x08+c | Capture register of channel c |
| 0x10+b | Holding register of buffered channel b |

Control word bits:

| Bit(s) | Name | Meaning |
|---|---|---|
| 0 | latch | 1 = latch mode, 0 = queue mode |
| 1 | buffer enable | holding registers operate only when set |
| 2 | fast clear | reading a capture register clears its flag |
| 3 | flag-on-hold | in queue mode, flags follow holding-register loads |
| 4 | software latch | write-only strobe, reads as 0 |
| 6:5 | delay select | filter delay setting |
| 8+b | no-overwrite | one bit per buffered channel b |

## Requirements
- R1: Edge code per channel: 00 = no capture, 01 = rising edges only, 10 = falling edges only, 11 = both edges. A transition that the code does not select leaves the capture register and the flag unchanged.
- R2: An accepted edge loads `cnt_i` into the channel's capture register and sets its flag. `irq_o[c]` is high exactly when flag c and interrupt enable c are both set.
- R3: On buffered channels, delay select 00 disables the filter; 01, 10 and 11 wait 256, 512 and 1024 clocks (`DLY_UNIT` times 1, 2 and 4). The transition is accepted only if the synchronised pin still holds the new level when the wait ends, so a shorter pulse causes no capture.
- R4: In queue mode with the buffer enabled, a capture on a buffered channel that already holds a value moves the old capture value into the holding register and then stores the new counter value.
- R5: In latch mode with the buffer enabled, an external strobe pulse or a control write with the software-latch bit (bit 4) set copies every buffered capture register into its holding register. Captures in this mode do not move values into the holding register.
- R6: With a channel's no-overwrite bit (control bit 8+b) set, a capture is dropped while the capture register holds a value that has been neither read nor latched. In queue mode the drop happens instead while the holding register is unread. A latch copy skips an unread holding register.
- R7: In queue mode with flag-on-hold (control bit 3) set, a buffered channel's flag is set only when its holding register is loaded. The first capture into an empty channel therefore raises no flag.
- R8: Polarity bit b records 1 if the first capture after arming came from a rising edge and 0 if it came from a falling edge. Writing 1 to bit b of address 0x04 re-arms it, and reset arms all bits.
- R9: Writing 1 to a flag bit clears it. With fast clear (control bit 2) set, flag writes have no effect and reading a capture register clears that channel's flag instead.
- R10: After reset all registers, flags, interrupt outputs and polarity bits read 0.
- R11: While buffer enable (control bit 1) is clear, holding registers keep their contents, including across latch strobes and captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_CH | Capture pins (asynchronous) |
| cnt_i | input | CNT_W | Free-running counter value |
| latch_strobe_i | input | 1 | External latch strobe, one-cycle pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects only) |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| flags_o | output | N_CH | Channel flags |
| irq_o | output | N_CH | Per-channel interrupt requests |

## Verification
The bound checker watches every cycle for these conditions:
- no flag rises on a channel whose edge code is 00;
- no flag falls without a register access;
- a protected capture register never changes while it holds an unread value outside queue mode;
- a latch copy always leaves each holding register equal to its capture register's previous value;
- holding registers stay frozen while the buffer is disabled.

Only the bench scenarios can show the following: the actual counter values captured on each edge kind, the queue shift order, the first-capture flag suppression of flag-on-hold mode, polarity recording and re-arming, fast clear, and the delay filter rejecting a short pulse while accepting a held level.

// File: rtl/bcu_pkg.sv
`timescale 1ns/1ps
package bcu_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned CAP_BASE  = 8;
  localparam int unsigned HOLD_BASE = 16;

  localparam logic [ADDR_W-1:0] A_EDGE = 5'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 5'd2;
  localparam logic [ADDR_W-1:0] A_IE   = 5'd3;
  localparam logic [ADDR_W-1:0] A_POL  = 5'd4;

  localparam int unsigned C_LATCH = 0;
  localparam int unsigned C_BUFEN = 1;
  localparam int unsigned C_FAST  = 2;
  localparam int unsigned C_FHOLD = 3;
  localparam int unsigned C_SLAT  = 4;
  localparam int unsigned C_DLY   = 5;
  localparam int unsigned C_NOV   = 8;

  function automatic logic edge_hit(input logic [1:0] code, input logic acc, input logic rise);
    case (edge_sel_e'(code))
      EDGE_RISE: return acc & rise;
      EDGE_FALL: return acc & ~rise;
      EDGE_ANY:  return acc;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bcu_sync.sv
`timescale 1ns/1ps
module bcu_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[0], pin_i};
  end

  assign lvl_o = ff_q[1];
endmodule

// File: rtl/bcu_dly_filter.sv
`timescale 1ns/1ps
module bcu_dly_filter #(
  parameter int unsigned DLY_UNIT = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] sel_i,
  output logic       acc_o,
  output logic       rise_o
);
  localparam int unsigned LIM_MAX = DLY_UNIT * 4;
  localparam int unsigned CW      = $clog2(LIM_MAX + 1);

  logic          ref_q, busy_q;
  logic [CW-1:0] cnt_q, lim;
  logic          diff, expire;

  always_comb begin
    case (sel_i)
      2'b01:   lim = CW'(DLY_UNIT);
      2'b10:   lim = CW'(DLY_UNIT * 2);
      2'b11:   lim = CW'(LIM_MAX);
      default: lim = '0;
    endcase
  end

  assign diff   = lvl_i != ref_q;
  assign expire = busy_q && (cnt_q >= lim);
  // level must still differ from the last accepted level at expiry
  assign acc_o  = diff && (busy_q ? expire : (sel_i == 2'b00));
  assign rise_o = lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (acc_o) ref_q <= lvl_i;
      if (busy_q) begin
        if (expire) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + 1'b1;
      end else if (diff && sel_i != 2'b00) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
      end
    end
  end
endmodule

// File: rtl/buf_capture_unit.sv
`timescale 1ns/1ps
module buf_capture_unit
  import bcu_pkg::*;
#(
  parameter int unsigned N_CH     = 8,
  parameter int unsigned N_BUF    = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DLY_UNIT = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   pin_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              latch_strobe_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   flags_o,
  output logic [N_CH-1:0]   irq_o
);
  localparam int unsigned EW = 2 * N_CH;

  logic [EW-1:0]    edge_q;
  logic             latch_mode_q, buf_en_q, fast_clr_q, flag_hold_q;
  logic [1:0]       dly_q;
  logic [N_BUF-1:0] nov_q;
  logic [N_CH-1:0]  flag_q, ie_q;

  logic [N_CH-1:0][CNT_W-1:0]  cap_q;
  logic [N_BUF-1:0][CNT_W-1:0] hold_q;
  logic [N_CH-1:0]  cap_full_q, hit, take, blocked, fset, lat_clr, rise, rd_cap;
  logic [N_BUF-1:0] hold_full_q, cap_valid_q, shift, lat_cp, rd_hold, pol_q;

  logic wr_edge, wr_ctrl, wr_flag, wr_ie, wr_pol, soft_latch, queue_act, latch_evt;
  logic [N_CH-1:0] clr_mask;

  assign wr_edge    = wr_en_i && addr_i == A_EDGE;
  assign wr_ctrl    = wr_en_i && addr_i == A_CTRL;
  assign wr_flag    = wr_en_i && addr_i == A_FLAG;
  assign wr_ie      = wr_en_i && addr_i == A_IE;
  assign wr_pol     = wr_en_i && addr_i == A_POL;
  assign soft_latch = wr_ctrl && wdata_i[C_SLAT];
  assign queue_act  = buf_en_q & ~latch_mode_q;
  assign latch_evt  = buf_en_q & latch_mode_q & (latch_strobe_i | soft_latch);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q       <= '0;
      latch_mode_q <= 1'b0;
      buf_en_q     <= 1'b0;
      fast_clr_q   <= 1'b0;
      flag_hold_q  <= 1'b0;
      dly_q        <= '0;
      nov_q        <= '0;
      ie_q         <= '0;
    end else begin
      if (wr_edge) edge_q <= wdata_i[EW-1:0];
      if (wr_ie)   ie_q   <= wdata_i[N_CH-1:0];
      if (wr_ctrl) begin
        latch_mode_q <= wdata_i[C_LATCH];
        buf_en_q     <= wdata_i[C_BUFEN];
        fast_clr_q   <= wdata_i[C_FAST];
        flag_hold_q  <= wdata_i[C_FHOLD];
        dly_q        <= wdata_i[C_DLY +: 2];
        nov_q        <= wdata_i[C_NOV +: N_BUF];
      end
    end
  end

  // per-channel front end and capture register
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic             lvl, acc;
    logic [CNT_W-1:0] cap_r;
    logic             full_r;

    assign rd_cap[c] = rd_en_i && addr_i == ADDR_W'(CAP_BASE + c);

    bcu_sync u_sync (.clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i[c]), .lvl_o(lvl));

    if (c < N_BUF) begin : g_flt
      bcu_dly_filter #(.DLY_UNIT(DLY_UNIT)) u_flt (
        .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .sel_i(dly_q),
        .acc_o(acc), .rise_o(rise[c]));
    end else begin : g_raw
      bcu_dly_filter #(.DLY_UNIT(DLY_UNIT)) u_flt (
        .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .sel_i(2'b00),
        .acc_o(acc), .rise_o(rise[c]));
      assign blocked[c] = 1'b0;
      assign fset[c]    = take[c];
      assign lat_clr[c] = 1'b0;
    end

    assign hit[c]  = edge_hit(edge_q[2*c +: 2], acc, rise[c]);
    assign take[c] = hit[c] & ~blocked[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_r  <= '0;
        full_r <= 1'b0;
      end else begin
        if (take[c]) cap_r <= cnt_i;
        if (take[c])                       full_r <= 1'b1;
        else if (rd_cap[c] || lat_clr[c])  full_r <= 1'b0;
      end
    end

    assign cap_q[c]      = cap_r;
    assign cap_full_q[c] = full_r;
  end

  // holding registers, protection, polarity
  for (genvar b = 0; b < N_BUF; b++) begin : g_buf
    logic [CNT_W-1:0] hold_r;
    logic             hfull_r, valid_r, pol_r, arm_r;

    assign rd_hold[b] = rd_en_i && addr_i == ADDR_W'(HOLD_BASE + b);
    assign blocked[b] = nov_q[b] & (queue_act ? (valid_r & hfull_r) : cap_full_q[b]);
    assign shift[b]   = take[b] & queue_act & valid_r;
    assign lat_cp[b]  = latch_evt & ~(nov_q[b] & hfull_r);
    assign lat_clr[b] = lat_cp[b];
    assign fset[b]    = (queue_act & flag_hold_q) ? shift[b] : take[b];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_r  <= '0;
        hfull_r <= 1'b0;
        valid_r <= 1'b0;
        pol_r   <= 1'b0;
        arm_r   <= 1'b1;
      end else begin
        if (shift[b] || lat_cp[b]) hold_r <= cap_q[b];
        if (shift[b] || lat_cp[b]) hfull_r <= 1'b1;
        else if (rd_hold[b])       hfull_r <= 1'b0;
        if (take[b]) valid_r <= 1'b1;
        if (take[b] && arm_r) begin
          pol_r <= rise[b];
          arm_r <= 1'b0;
        end else if (wr_pol && wdata_i[b]) begin
          arm_r <= 1'b1;
        end
      end
    end

    assign hold_q[b]      = hold_r;
    assign hold_full_q[b] = hfull_r;
    assign cap_valid_q[b] = valid_r;
    assign pol_q[b]       = pol_r;
  end

  always_comb begin
    clr_mask = '0;
    if (fast_clr_q)   clr_mask = rd_cap;
    else if (wr_flag) clr_mask = wdata_i[N_CH-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_mask) | fset;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_EDGE: rdata_o = DATA_W'(edge_q);
      A_CTRL: begin
        rdata_o[C_LATCH]       = latch_mode_q;
        rdata_o[C_BUFEN]       = buf_en_q;
        rdata_o[C_FAST]        = fast_clr_q;
        rdata_o[C_FHOLD]       = flag_hold_q;
        rdata_o[C_DLY +: 2]    = dly_q;
        rdata_o[C_NOV +: N_BUF] = nov_q;
      end
      A_FLAG: rdata_o = DATA_W'(flag_q);
      A_IE:   rdata_o = DATA_W'(ie_q);
      A_POL:  rdata_o = DATA_W'(pol_q);
      default: begin
        for (int c = 0; c < N_CH; c++)
          if (addr_i == ADDR_W'(CAP_BASE + c)) rdata_o = DATA_W'(cap_q[c]);
        for (int b = 0; b < N_BUF; b++)
          if (addr_i == ADDR_W'(HOLD_BASE + b)) rdata_o = DATA_W'(hold_q[b]);
      end
    endcase
  end

  assign flags_o = flag_q;
  assign irq_o   = flag_q & ie_q;
endmodule

// File: rtl/buf_capture_chk.sv
`timescale 1ns/1ps
module buf_capture_chk #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned N_BUF = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wr_en_i,
  input logic                        rd_en_i,
  input logic [N_CH-1:0]             flags_o,
  input logic [2*N_CH-1:0]           edge_q,
  input logic                        buf_en_q,
  input logic                        queue_act,
  input logic                        latch_evt,
  input logic [N_BUF-1:0]            nov_q,
  input logic [N_CH-1:0]             cap_full_q,
  input logic [N_BUF-1:0]            hold_full_q,
  input logic [N_CH-1:0][CNT_W-1:0]  cap_q,
  input logic [N_BUF-1:0][CNT_W-1:0] hold_q
);
  logic [N_CH-1:0] en_mask;
  always_comb
    for (int c = 0; c < N_CH; c++) en_mask[c] = |edge_q[2*c +: 2];

  a_r1_disabled_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(en_mask)) == '0));

  a_r9_clear_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~flags_o & $past(flags_o))) |-> $past(wr_en_i || rd_en_i));

  a_r11_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_en_q |=> $stable(hold_q));

  for (genvar b = 0; b < N_BUF; b++) begin : g_b
    a_r5_latch_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_evt && !(nov_q[b] && hold_full_q[b])) |=> hold_q[b] == $past(cap_q[b]));

    a_r6_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nov_q[b] && !queue_act && cap_full_q[b]) |=> $stable(cap_q[b]));
  end
endmodule

bind buf_capture_unit buf_capture_chk #(.N_CH(N_CH), .N_BUF(N_BUF), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .flags_o(flags_o), .edge_q(edge_q), .buf_en_q(buf_en_q), .queue_act(queue_act),
  .latch_evt(latch_evt), .nov_q(nov_q), .cap_full_q(cap_full_q),
  .hold_full_q(hold_full_q), .cap_q(cap_q), .hold_q(hold_q));

// File: tb/test_buf_capture_unit.sv
`timescale 1ns/1ps
module test_buf_capture_unit;
  import bcu_pkg::*;
  localparam int N_CH = 8, CNT_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_ni = 1'b0;
  logic [N_CH-1:0]   pin_i = '0;
  logic [CNT_W-1:0]  cnt_i = '0;
  logic              latch_strobe_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic [N_CH-1:0]   flags_o, irq_o;

  buf_capture_unit i_buf_capture_unit (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin_i), .cnt_i(cnt_i),
    .latch_strobe_i(latch_strobe_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .flags_o(flags_o), .irq_o(irq_o));

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] exp;
    string             tag;
  } item_t;

  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // monitor: pops expected read results and compares them
  always @(posedge clk) begin
    if (rd_en_i && sb.size() > 0) begin
      item_t it;
      #3;
      it = sb.pop_front();
      checks++;
      if (rdata_o !== it.exp) begin
        fails++;
        $display("FAIL %s addr=%0h actual=%h expected=%h", it.tag, it.addr, rdata_o, it.exp);
      end
    end
  end

  task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic set_pin(input int c, input logic v);
    @(negedge clk);
    pin_i[c] = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk);
    latch_strobe_i = 1'b1;
    @(negedge clk);
    latch_strobe_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic port_chk(input string tag, input logic [N_CH-1:0] act, input logic [N_CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10 reset state
    port_chk("R10 irq", irq_o, '0);
    rd_exp(A_FLAG, 16'h0000, "R10 flags");
    rd_exp(A_CTRL, 16'h0000, "R10 ctrl");
    rd_exp(5'd8, 16'h0000, "R10 cap0");
    rd_exp(5'd16, 16'h0000, "R10 hold0");
    rd_exp(A_POL, 16'h0000, "R10 pol");

    // R1: ch0 rise, ch1 fall, ch2 any, ch3 off, ch4 rise
    wr(A_EDGE, 16'h0139);
    cnt_i = 16'h1111;
    for (int c = 0; c < 5; c++) set_pin(c, 1'b1);
    rd_exp(A_FLAG, 16'h0015, "R1 rising edges");
    rd_exp(5'd8, 16'h1111, "R1 cap0");
    rd_exp(5'd11, 16'h0000, "R1 disabled ch3");
    rd_exp(5'd12, 16'h1111, "R2 cap4 plain channel");
    cnt_i = 16'h2222;
    for (int c = 0; c < 4; c++) set_pin(c, 1'b0);
    rd_exp(A_FLAG, 16'h0017, "R1 falling edges");
    rd_exp(5'd9, 16'h2222, "R1 cap1 falling");
    rd_exp(5'd10, 16'h2222, "R1 cap2 any");
    rd_exp(5'd8, 16'h1111, "R1 cap0 ignores fall");
    rd_exp(5'd18, 16'h0000, "R11 hold2 with buffer off");

    // R2 interrupts
    wr(A_IE, 16'h0001);
    @(negedge clk); port_chk("R2 irq ch0", irq_o, 8'h01);
    wr(A_IE, 16'h0010);
    @(negedge clk); port_chk("R2 irq ch4", irq_o, 8'h10);
    wr(A_IE, 16'h0000);

    // R9 clearing
    wr(A_FLAG, 16'h0001);
    rd_exp(A_FLAG, 16'h0016, "R9 write one clears");
    wr(A_CTRL, 16'h0004);
    wr(A_FLAG, 16'h0002);
    rd_exp(A_FLAG, 16'h0016, "R9 write ignored in fast clear");
    rd_exp(5'd9, 16'h2222, "R9 read cap1");
    rd_exp(A_FLAG, 16'h0014, "R9 fast clear by read");
    wr(A_CTRL, 16'h0000);
    wr(A_FLAG, 16'h00FF);
    rd_exp(A_FLAG, 16'h0000, "R9 clear all");

    // R4 queue mode
    wr(A_CTRL, 16'h0002);
    cnt_i = 16'h3333;
    set_pin(2, 1'b1);
    rd_exp(5'd10, 16'h3333, "R4 cap2 new");
    rd_exp(5'd18, 16'h2222, "R4 hold2 old");
    wr(A_POL, 16'h0004);
    cnt_i = 16'h4444;
    set_pin(2, 1'b0);
    rd_exp(5'd10, 16'h4444, "R4 cap2 second");
    rd_exp(5'd18, 16'h3333, "R4 hold2 second");

    // R7 flag on hold load
    wr(A_FLAG, 16'h00FF);
    wr(A_CTRL, 16'h000A);
    wr(A_EDGE, 16'h0179);
    cnt_i = 16'h5555;
    set_pin(3, 1'b1);
    rd_exp(A_FLAG, 16'h0000, "R7 no flag on first capture");
    rd_exp(5'd11, 16'h5555, "R7 cap3 first");
    set_pin(3, 1'b0);
    cnt_i = 16'h6666;
    set_pin(3, 1'b1);
    rd_exp(A_FLAG, 16'h0008, "R7 flag on hold load");
    rd_exp(5'd19, 16'h5555, "R7 hold3");
    rd_exp(5'd11, 16'h6666, "R7 cap3 second");

    // R8 polarity: ch0 rise, ch1 fall, ch2 re-armed then fall, ch3 rise
    rd_exp(A_POL, 16'h0009, "R8 polarity record");

    // R5 latch mode
    wr(A_FLAG, 16'h00FF);
    wr(A_CTRL, 16'h0003);
    strobe();
    rd_exp(5'd16, 16'h1111, "R5 strobe hold0");
    rd_exp(5'd19, 16'h6666, "R5 strobe hold3");
    cnt_i = 16'h7777;
    set_pin(0, 1'b0);
    set_pin(0, 1'b1);
    rd_exp(5'd16, 16'h1111, "R5 no shift in latch mode");
    rd_exp(5'd8, 16'h7777, "R5 cap0");
    wr(A_CTRL, 16'h0013);
    rd_exp(5'd16, 16'h7777, "R5 software latch");

    // R11 buffer disabled blocks latch
    wr(A_CTRL, 16'h0001);
    cnt_i = 16'h8888;
    set_pin(0, 1'b0);
    set_pin(0, 1'b1);
    strobe();
    rd_exp(5'd16, 16'h7777, "R11 hold0 frozen");
    rd_exp(5'd8, 16'h8888, "R11 cap0");

    // R6 no-overwrite
    wr(A_CTRL, 16'h0103);
    cnt_i = 16'h9999;
    set_pin(0, 1'b0);
    set_pin(0, 1'b1);
    cnt_i = 16'hAAAA;
    set_pin(0, 1'b0);
    set_pin(0, 1'b1);
    rd_exp(5'd8, 16'h9999, "R6 unread value kept");
    cnt_i = 16'hBBBB;
    set_pin(0, 1'b0);
    set_pin(0, 1'b1);
    rd_exp(5'd8, 16'hBBBB, "R6 capture after read");

    // R3 delay filter, 256 clocks
    wr(A_CTRL, 16'h0000);
    set_pin(0, 1'b0);
    wr(A_FLAG, 16'h00FF);
    wr(A_CTRL, 16'h0020);
    cnt_i = 16'hC0C0;
    @(negedge clk); pin_i[0] = 1'b1;
    repeat (100) @(negedge clk);
    pin_i[0] = 1'b0;
    repeat (400) @(negedge clk);
    rd_exp(A_FLAG, 16'h0000, "R3 short pulse rejected");
    rd_exp(5'd8, 16'hBBBB, "R3 cap0 unchanged");
    pin_i[0] = 1'b1;
    repeat (150) @(negedge clk);
    rd_exp(A_FLAG, 16'h0000, "R3 not before delay");
    repeat (300) @(negedge clk);
    rd_exp(A_FLAG, 16'h0001, "R3 accepted after delay");
    rd_exp(5'd8, 16'hC0C0, "R3 cap0 filtered");

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule